// File: doc/BRIEF.md
# Memory-Mapped Periodic Tick Timer

This block is a down-counting periodic timer reached through a small word-wide register interface. Software programs a 24-bit reload value and turns the timer on. The counter then steps down once per tick of the selected time base until it reaches zero. On the next tick it expires and starts again from the reload value. Each expiry sets a sticky status flag. When interrupts are enabled, each expiry also raises a one-cycle interrupt pulse. The time base is either every core clock cycle or a slower reference-tick enable strobe. A control bit chooses between them.

The interface takes one request per cycle and answers one cycle later. Privileged accesses are served. Unprivileged accesses get an error response and change nothing. Some accesses have side effects: reading the control/status word clears the sticky flag, and any write to the current-value word restarts the period. If the reload value is zero when the counter expires, the timer switches itself off.

Top module: `tick_timer`

## Requirements
- R1: After reset the control/status, reload and current-value words all read 0, and `irq` is low.
- R2: Word offsets are fixed. 0x0 is control/status, 0x4 is reload, 0x8 is current value and 0xC is calibration. The calibration word always reads 10000 (decimal). Any other offset reads 0 and ignores writes. `bus_rvalid` is high in the cycle after every request, with `bus_rdata`/`bus_err` valid in that cycle.
- R3: A control write changes only bit 0 (run), bit 1 (interrupt enable) and bit 2 (time base, 1 = every core clock, 0 = `ref_tick` strobe). Bit 16 is the sticky expiry flag and cannot be written. All other bits read 0.
- R4: While running, the counter steps once per tick of the selected time base and holds still between ticks. One period spans reload+1 ticks, from the load of the reload value to the expiry.
- R5: An expiry sets the flag. If bit 1 is 1, `irq` is high for exactly one cycle. If bit 1 is 0, `irq` stays low.
- R6: Reading the control/status word returns the flag and then clears it. An expiry in the same cycle leaves the flag set.
- R7: A write of any data to the current-value word loads the counter from the reload value and clears the flag.
- R8: If the reload value is 0 when the counter expires, bit 0 clears and counting stops. The flag is still set.
- R9: The current-value word reads 0 while bit 0 is 0. Clearing bit 0 freezes the count. Setting bit 0 again resumes from the frozen count if it is nonzero, and loads the reload value otherwise.
- R10: The reload and current-value words keep only bits [23:0]. Bits [31:24] read 0.
- R11: An unprivileged read or write gets `bus_err` high with `bus_rdata` 0. It writes nothing and does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | Reference time-base strobe, one cycle per tick |
| bus_req | input | 1 | Access request for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 8 | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Response valid, one cycle after the request |
| bus_rdata | output | 32 | Read data (0 for writes and errors) |
| bus_err | output | 1 | Error response for unprivileged access |
| irq | output | 1 | One-cycle pulse on expiry when interrupts are enabled |

## Verification
The bench runs the timer from the reference strobe so that every count value is predictable. It holds the strobe idle to show that the count does not move. It measures the spacing between interrupt pulses on the core clock. A period that is off by one would show up as a spacing of reload or reload+2 instead of reload+1. The bench checks that a second status read finds the flag gone: a design without read-clear would return the flag twice. A zero reload value must switch the timer off after one expiry, so a design that kept counting would still show the run bit set. The bench also checks that a disable followed by re-enable resumes from the frozen count rather than reloading. Finally, it checks that an unprivileged status read does not consume the flag.

// File: rtl/tick_pkg.sv
// Shared constants for the periodic tick timer: word offsets, control bit
// positions and the fixed calibration value.
package tick_pkg;
    localparam int unsigned OFS_CTRL   = 'h0;
    localparam int unsigned OFS_RELOAD = 'h4;
    localparam int unsigned OFS_CUR    = 'h8;
    localparam int unsigned OFS_CALIB  = 'hC;

    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_INTEN  = 1;
    localparam int unsigned BIT_CORE   = 2;
    localparam int unsigned BIT_FLAG   = 16;

    localparam int unsigned CALIB_VALUE = 10000;
endpackage

// File: rtl/tick_src_sel.sv
// Time-base selector.
// Produces the per-cycle step enable for the counter: every cycle when the
// core clock is selected, on each ref_tick strobe otherwise. Assumes ref_tick
// is already synchronous to clk and one cycle wide per tick.
module tick_src_sel (
    input  logic run,
    input  logic core_sel,
    input  logic ref_tick,
    output logic tick_en
);
    // Gate the chosen time base with the run bit.
    always_comb begin
        tick_en = run & (core_sel | ref_tick);
    end
endmodule

// File: rtl/tick_down_counter.sv
// Down counter with reload.
// Steps down once per tick_en; a tick at zero is an expiry and reloads.
// force_load (current-value write) has priority and suppresses expiry; start
// (run 0->1) resumes a nonzero frozen count or loads the reload value.
// Assumes start and tick_en are never high together (tick_en needs run=1).
module tick_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic             force_load,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cur_q;
    logic             cur_zero;

    // Expiry detection: a tick that finds the counter at zero.
    always_comb begin
        cur_zero = (cur_q == '0);
        expire   = tick_en & cur_zero & ~force_load;
    end

    // Count register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (force_load) begin
            cur_q <= reload_val;
        end else if (start) begin
            cur_q <= cur_zero ? reload_val : cur_q;
        end else if (tick_en) begin
            cur_q <= cur_zero ? reload_val : cur_q - CNT_W'(1);
        end
    end

    assign count = cur_q;

    // R4: a plain tick moves the count down by exactly one.
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !force_load && !start && cur_q != '0) |=> (cur_q == $past(cur_q) - CNT_W'(1)))
        else $error("count did not step down by one");

    // R4: the tick at zero restarts the period from the reload value.
    assert_wrap_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !force_load && cur_q == '0) |=> (cur_q == $past(reload_val)))
        else $error("expiry did not reload");
endmodule

// File: rtl/tick_reg_file.sv
// Register file and bus responder for the tick timer.
// Holds run/interrupt-enable/time-base bits, the sticky flag and the reload
// value; decodes privileged accesses, applies read/write side effects and
// registers a response one cycle after each request. Assumes word offsets.
module tick_reg_file #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              priv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic              run,
    output logic              core_sel,
    output logic [CNT_W-1:0]  reload,
    output logic              start,
    output logic              force_load,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic              irq
);
    import tick_pkg::*;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CUR    = ADDR_W'(OFS_CUR);
    localparam logic [ADDR_W-1:0] A_CALIB  = ADDR_W'(OFS_CALIB);

    logic             run_q, inten_q, core_q, flag_q, irq_q;
    logic [CNT_W-1:0] reload_q;
    logic             acc_ok, wr_ctrl, wr_reload, wr_cur, rd_ctrl;
    logic [DATA_W-1:0] rd_mux;
    logic             unused_wdata;

    assign unused_wdata = ^wdata;

    // Access decode: only privileged requests have side effects.
    always_comb begin
        acc_ok    = req & priv;
        wr_ctrl   = acc_ok & we & (addr == A_CTRL);
        wr_reload = acc_ok & we & (addr == A_RELOAD);
        wr_cur    = acc_ok & we & (addr == A_CUR);
        rd_ctrl   = acc_ok & ~we & (addr == A_CTRL);
        start      = wr_ctrl & wdata[BIT_RUN] & ~run_q;
        force_load = wr_cur;
    end

    // Control bits: self-stop on zero-reload expiry, then software write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            inten_q <= 1'b0;
            core_q  <= 1'b0;
        end else begin
            if (expire && reload_q == '0) run_q <= 1'b0;
            if (wr_ctrl) begin
                run_q   <= wdata[BIT_RUN];
                inten_q <= wdata[BIT_INTEN];
                core_q  <= wdata[BIT_CORE];
            end
        end
    end

    // Sticky flag: cleared by status read or current write, set by expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            if (rd_ctrl || wr_cur) flag_q <= 1'b0;
            if (expire) flag_q <= 1'b1;
        end
    end

    // Reload value register, truncated to the counter width.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= '0;
        else if (wr_reload) reload_q <= wdata[CNT_W-1:0];
    end

    // Interrupt pulse: one cycle per expiry when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else irq_q <= expire & inten_q;
    end

    // Read data selection by offset.
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CTRL: begin
                rd_mux[BIT_RUN]   = run_q;
                rd_mux[BIT_INTEN] = inten_q;
                rd_mux[BIT_CORE]  = core_q;
                rd_mux[BIT_FLAG]  = flag_q;
            end
            A_RELOAD: rd_mux = DATA_W'(reload_q);
            A_CUR:    rd_mux = run_q ? DATA_W'(count) : '0;
            A_CALIB:  rd_mux = DATA_W'(CALIB_VALUE);
            default:  rd_mux = '0;
        endcase
    end

    // Registered response, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= req;
            rsp_err   <= req & ~priv;
            rsp_data  <= (acc_ok && !we) ? rd_mux : '0;
        end
    end

    assign run      = run_q;
    assign core_sel = core_q;
    assign reload   = reload_q;
    assign irq      = irq_q;

    // R5: the interrupt is never wider than one cycle.
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q) else $error("irq wider than one cycle");

    // R11: an error response never carries data.
    assert_err_no_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_data == '0)) else $error("error response with data");

    // R6: a status read without a coincident expiry leaves the flag clear.
    assert_flag_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !expire) |=> !flag_q) else $error("flag survived read");

    // R8: zero-reload expiry switches the timer off.
    assert_stop_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && reload_q == '0 && !wr_ctrl) |=> !run_q) else $error("timer kept running");
endmodule

// File: rtl/tick_timer.sv
// Top of the periodic tick timer.
// Connects the register file, time-base selector and down counter.
// Assumes a synchronous ref_tick strobe and single-word accesses.
module tick_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_req,
    input  logic              bus_write,
    input  logic              bus_priv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq
);
    logic             run, core_sel, start, force_load, tick_en, expire;
    logic [CNT_W-1:0] reload, count;

    tick_reg_file #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_write), .priv(bus_priv),
        .addr(bus_addr), .wdata(bus_wdata), .count(count), .expire(expire),
        .run(run), .core_sel(core_sel), .reload(reload), .start(start),
        .force_load(force_load), .rsp_valid(bus_rvalid), .rsp_err(bus_err),
        .rsp_data(bus_rdata), .irq(irq)
    );

    tick_src_sel u_src (
        .run(run), .core_sel(core_sel), .ref_tick(ref_tick), .tick_en(tick_en)
    );

    tick_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .start(start),
        .force_load(force_load), .reload_val(reload), .count(count), .expire(expire)
    );
endmodule

// File: tb/tick_timer_tb.sv
// Directed bench for tick_timer: one task per scenario, each checking itself.
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_req = 1'b0, bus_write = 1'b0, bus_priv = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, bus_err, irq;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_req(bus_req),
        .bus_write(bus_write), .bus_priv(bus_priv), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq(irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One access; returns the response seen one cycle later.
    task automatic bus(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic priv, output logic [31:0] rd, output logic err);
        @(negedge clk);
        bus_req = 1'b1; bus_write = we; bus_addr = a; bus_wdata = d; bus_priv = priv;
        @(negedge clk);
        bus_req = 1'b0; bus_write = 1'b0; bus_priv = 1'b1;
        if (!bus_rvalid) begin
            errors = errors + 1;
            $display("FAIL R2 rvalid: actual 0 expected 1");
        end
        rd = bus_rdata; err = bus_err;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] rd; logic e;
        bus(1'b1, a, d, 1'b1, rd, e);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic e;
        bus(1'b0, a, 32'h0, 1'b1, rd, e);
        chk(tag, rd, exp);
    endtask

    // One reference strobe; reports whether irq was seen right after it.
    task automatic pulse_ref(output logic saw);
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0; saw = irq;
    endtask

    task automatic t_reset;
        chk("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R1 ctrl", 8'h0, 32'h0);
        rd_chk("R1 reload", 8'h4, 32'h0);
        rd_chk("R1 current", 8'h8, 32'h0);
    endtask

    task automatic t_map;
        wr(8'h4, 32'hFFFF_FFFF);
        rd_chk("R10 reload upper bits", 8'h4, 32'h00FF_FFFF);
        rd_chk("R2 calibration", 8'hC, 32'd10000);
        rd_chk("R2 undefined read", 8'h10, 32'h0);
        wr(8'h10, 32'h1234_5678);
        rd_chk("R2 undefined write ignored", 8'h4, 32'h00FF_FFFF);
    endtask

    task automatic t_ctrl_bits;
        wr(8'h0, 32'hFFFF_FFFE);
        rd_chk("R3 only low bits written", 8'h0, 32'h0000_0006);
        wr(8'h0, 32'h0);
    endtask

    task automatic t_period;
        int n;
        wr(8'h4, 32'd4);
        wr(8'h0, 32'h7);
        n = 0;
        while (!irq && n < 200) begin @(negedge clk); n++; end
        chk("R5 irq seen", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R5 irq one cycle", {31'b0, irq}, 32'h0);
        n = 1;
        while (!irq && n < 50) begin @(negedge clk); n++; end
        chk("R4 core period reload+1", n, 32'd5);
        wr(8'h0, 32'h6);
        rd_chk("R6 flag read", 8'h0, 32'h0001_0006);
        rd_chk("R6 flag cleared by read", 8'h0, 32'h0000_0006);
        wr(8'h0, 32'h5);
        n = 0;
        for (int i = 0; i < 14; i++) begin @(negedge clk); if (irq) n++; end
        chk("R5 no irq when disabled", n, 32'd0);
        wr(8'h0, 32'h4);
        rd_chk("R5 flag without irq", 8'h0, 32'h0001_0004);
    endtask

    task automatic t_ref;
        logic saw;
        wr(8'h0, 32'h0);
        rd_chk("R9 disabled current reads 0", 8'h8, 32'h0);
        wr(8'h4, 32'd2);
        wr(8'h8, 32'hDEAD_BEEF);
        wr(8'h0, 32'h3);
        rd_chk("R7 current loaded", 8'h8, 32'd2);
        repeat (10) @(negedge clk);
        rd_chk("R4 no step without ref tick", 8'h8, 32'd2);
        pulse_ref(saw);
        rd_chk("R4 ref step", 8'h8, 32'd1);
        pulse_ref(saw);
        chk("R5 no irq before expiry", {31'b0, saw}, 32'h0);
        pulse_ref(saw);
        chk("R5 irq on ref expiry", {31'b0, saw}, 32'h1);
        rd_chk("R4 reloaded after expiry", 8'h8, 32'd2);
        wr(8'h8, 32'h0);
        rd_chk("R7 flag cleared by current write", 8'h0, 32'h0000_0003);
    endtask

    task automatic t_freeze;
        logic saw;
        wr(8'h0, 32'h0);
        wr(8'h4, 32'd10);
        wr(8'h8, 32'h0);
        wr(8'h0, 32'h1);
        rd_chk("R9 start from loaded count", 8'h8, 32'd10);
        pulse_ref(saw); pulse_ref(saw); pulse_ref(saw);
        rd_chk("R4 three ticks", 8'h8, 32'd7);
        wr(8'h0, 32'h0);
        rd_chk("R9 current 0 while off", 8'h8, 32'd0);
        pulse_ref(saw);
        wr(8'h0, 32'h1);
        rd_chk("R9 resume frozen count", 8'h8, 32'd7);
        wr(8'h8, 32'h5);
        rd_chk("R7 current write reloads", 8'h8, 32'd10);
    endtask

    task automatic t_zero_reload;
        logic saw;
        wr(8'h0, 32'h0);
        rd_chk("R6 clear before", 8'h0, 32'h0);
        wr(8'h4, 32'd0);
        wr(8'h8, 32'h0);
        wr(8'h0, 32'h1);
        rd_chk("R8 running", 8'h0, 32'h0000_0001);
        pulse_ref(saw);
        rd_chk("R8 stopped with flag", 8'h0, 32'h0001_0000);
        pulse_ref(saw);
        rd_chk("R8 stays stopped", 8'h0, 32'h0);
    endtask

    task automatic t_unpriv;
        logic [31:0] rd; logic e; logic saw;
        wr(8'h4, 32'd5);
        bus(1'b1, 8'h4, 32'd9, 1'b0, rd, e);
        chk("R11 write err", {31'b0, e}, 32'h1);
        rd_chk("R11 write ignored", 8'h4, 32'd5);
        bus(1'b0, 8'h4, 32'h0, 1'b0, rd, e);
        chk("R11 read err", {31'b0, e}, 32'h1);
        chk("R11 read data 0", rd, 32'h0);
        wr(8'h4, 32'd0);
        wr(8'h0, 32'h1);
        pulse_ref(saw);
        bus(1'b0, 8'h0, 32'h0, 1'b0, rd, e);
        chk("R11 unpriv ctrl read err", {31'b0, e}, 32'h1);
        rd_chk("R11 flag kept", 8'h0, 32'h0001_0000);
        bus(1'b0, 8'hC, 32'h0, 1'b1, rd, e);
        chk("R2 priv no err", {31'b0, e}, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_ctrl_bits();
        t_period();
        t_ref();
        t_freeze();
        t_zero_reload();
        t_unpriv();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule